// File: doc/BRIEF.md
# Command Mailbox Register Front End

This block is a small register window through which a host drives a command/status mailbox. The host first writes a byte count into the length register. It then streams that many bytes through a single data port, and each access advances an internal cursor. Writing the command register starts execution at once. When the command finishes, the block replaces the status, the length and the buffer contents with the command's results and rewinds the cursor. The host then reads the output back through the same data port, one byte per read.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls while a command is running, and that is the only back-pressure the block applies. The read response and the error report are single-cycle pulses with no ready signal, so the requester must always be able to accept them. Three commands are serviced inside the block: no-op, interface version and station address. Codes 3 to 8 belong to a receive/transmit engine outside the block and are only announced on a dispatch strobe.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset the status reads 0 (OK), the length reads 0, the cursor is 0, `req_ready` is high, and `rsp_valid`, `err_valid` and `ext_cmd_valid` are low.
- R2: A write to offset 2 with a value no greater than BUF_BYTES sets the length and clears the cursor. A larger value is refused with `err_valid` and `err_kind` = 0, and leaves both the length and the cursor unchanged.
- R3: With cursor < length, a data write (offset 4) stores `req_wdata[7:0]` at buffer[cursor], and a data read returns {8'h00, buffer[cursor]}. Either access then increments the cursor. With cursor >= length, the access reports `err_kind` = 1, stores nothing, returns 0 on a read, and leaves the cursor unchanged.
- R4: A write to offset 0 stores the command and starts it. `req_ready` is low from the cycle after acceptance until the command completes. On completion the status takes the result, the length takes the output byte count and the cursor returns to 0.
- R5: A command written while cursor differs from length reports `err_kind` = 2 in the cycle after acceptance, and the command still executes.
- R6: Command 0 completes with status 0 and length 0. Command 1 completes with status 0 and length 2, and its buffer holds API_VER with the low byte at index 0.
- R7: Command 2 completes with status 0 and length 6, and its buffer holds STATION with the most significant byte at index 0.
- R8: Any command code above 8 completes with status 1 (unknown command) and length 0.
- R9: Codes 3 to 8 complete with status 0 and length 0. In their completion cycle they raise `ext_cmd_valid` for one cycle, with the code's low four bits on `ext_cmd_code`.
- R10: Offset 0 reads the status and offset 2 reads the length, each zero-extended. A write or read to any offset other than 0, 2 or 4 reports `err_kind` = 3, changes no state, and a read returns 0.
- R11: Each accepted read gives exactly one `rsp_valid` pulse, one cycle after acceptance. `err_valid` likewise appears one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request (low while a command runs) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 16 | Read data |
| err_valid | output | 1 | Access or command error (one cycle) |
| err_kind | output | 2 | 0 bad length, 1 cursor out of range, 2 incomplete data, 3 bad offset |
| ext_cmd_valid | output | 1 | External command dispatched (one cycle) |
| ext_cmd_code | output | 4 | Dispatched command code |

## Verification
The bench builds the block with BUF_BYTES = 8. This puts the largest legal length (8) and the first refused length (9) within a few writes, and a 6-byte station address fills most of the buffer. It also overrides API_VER and STATION with values whose bytes are all distinct, so any error in byte order or index shows up as a miscompare. Expected read data and error reports are queued by the driver and matched in order against the response and error pulses. A separate queue is used for the external dispatch strobe.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_LEN  = 3'd2;
  localparam logic [2:0] OFS_DATA = 3'd4;

  localparam logic [15:0] CMD_NOP       = 16'd0;
  localparam logic [15:0] CMD_APIVER    = 16'd1;
  localparam logic [15:0] CMD_STATION   = 16'd2;
  localparam logic [15:0] CMD_EXT_FIRST = 16'd3;
  localparam logic [15:0] CMD_EXT_LAST  = 16'd8;

  localparam logic [7:0] ST_OK      = 8'd0;
  localparam logic [7:0] ST_UNKNOWN = 8'd1;

  typedef enum logic [1:0] {
    ERR_LEN        = 2'd0,
    ERR_RANGE      = 2'd1,
    ERR_INCOMPLETE = 2'd2,
    ERR_OFFSET     = 2'd3
  } mbx_err_e;
endpackage

// File: rtl/mbx_buf.sv
module mbx_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
  import mbx_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          LW       = 5,
  parameter logic [15:0] API_VER  = 16'h0102,
  parameter logic [47:0] STATION  = 48'h02005E102030
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   code,
  output logic          busy,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          done,
  output logic [7:0]    res_status,
  output logic [LW-1:0] res_len,
  output logic          ext_valid,
  output logic [3:0]    ext_code
);
  logic        run_q;
  logic [15:0] code_q;
  logic [2:0]  idx_q;
  logic [2:0]  olen;
  logic        is_ext;

  function automatic logic [7:0] pick_byte(input logic [15:0] c, input logic [2:0] i);
    logic [47:0] sh;
    if (c == CMD_APIVER) begin
      return (i == 3'd0) ? API_VER[7:0] : API_VER[15:8];
    end
    sh = STATION >> (6'd8 * (6'd5 - {3'd0, i}));
    return sh[7:0];
  endfunction

  always_comb begin
    unique case (code_q)
      CMD_APIVER:  olen = 3'd2;
      CMD_STATION: olen = 3'd6;
      default:     olen = 3'd0;
    endcase
  end

  assign is_ext     = (code_q >= CMD_EXT_FIRST) && (code_q <= CMD_EXT_LAST);
  assign busy       = run_q;
  assign done       = run_q && (idx_q == olen);
  assign buf_we     = run_q && (idx_q < olen);
  assign buf_waddr  = AW'(idx_q);
  assign buf_wdata  = pick_byte(code_q, idx_q);
  assign res_status = (code_q > CMD_EXT_LAST) ? ST_UNKNOWN : ST_OK;
  assign res_len    = LW'(olen);
  assign ext_valid  = done && is_ext;
  assign ext_code   = code_q[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      code_q <= CMD_NOP;
      idx_q  <= '0;
    end else if (!run_q) begin
      if (start) begin
        run_q  <= 1'b1;
        code_q <= code;
        idx_q  <= '0;
      end
    end else if (done) begin
      run_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 3'd1;
    end
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int          BUF_BYTES = 16,
  parameter logic [15:0] API_VER   = 16'h0102,
  parameter logic [47:0] STATION   = 48'h02005E102030
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        err_valid,
  output logic [1:0]  err_kind,
  output logic        ext_cmd_valid,
  output logic [3:0]  ext_cmd_code
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = $clog2(BUF_BYTES + 1);

  logic [15:0]   cmd_q;
  logic [7:0]    status_q;
  logic [LW-1:0] length_q;
  logic [LW-1:0] cursor_q;

  logic          acc, is_cmd, is_len, is_data, cur_ok, len_ok;
  logic          host_we, exec_start;
  logic          ex_busy, ex_we, ex_done;
  logic [AW-1:0] ex_waddr, buf_waddr;
  logic [7:0]    ex_wdata, buf_wdata, buf_rdata;
  logic [7:0]    ex_status;
  logic [LW-1:0] ex_len;

  assign req_ready  = !ex_busy;
  assign acc        = req_valid && req_ready;
  assign is_cmd     = (req_addr == OFS_CMD);
  assign is_len     = (req_addr == OFS_LEN);
  assign is_data    = (req_addr == OFS_DATA);
  assign cur_ok     = (cursor_q < length_q);
  assign len_ok     = (req_wdata <= 16'(BUF_BYTES));
  assign host_we    = acc && req_write && is_data && cur_ok;
  assign exec_start = acc && req_write && is_cmd;

  assign buf_waddr  = ex_we ? ex_waddr : cursor_q[AW-1:0];
  assign buf_wdata  = ex_we ? ex_wdata : req_wdata[7:0];

  mbx_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk   (clk),
    .we    (ex_we || host_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (cursor_q[AW-1:0]),
    .rdata (buf_rdata)
  );

  mbx_exec #(
    .AW(AW), .LW(LW), .API_VER(API_VER), .STATION(STATION)
  ) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (exec_start),
    .code       (req_wdata),
    .busy       (ex_busy),
    .buf_we     (ex_we),
    .buf_waddr  (ex_waddr),
    .buf_wdata  (ex_wdata),
    .done       (ex_done),
    .res_status (ex_status),
    .res_len    (ex_len),
    .ext_valid  (ext_cmd_valid),
    .ext_code   (ext_cmd_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      status_q  <= ST_OK;
      length_q  <= '0;
      cursor_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_valid <= 1'b0;
      err_kind  <= ERR_LEN;
    end else begin
      rsp_valid <= 1'b0;
      err_valid <= 1'b0;
      if (ex_done) begin
        status_q <= ex_status;
        length_q <= ex_len;
        cursor_q <= '0;
      end else if (acc) begin
        if (!req_write) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
        end
        unique case (1'b1)
          is_cmd: begin
            if (req_write) begin
              cmd_q <= req_wdata;
              if (cursor_q != length_q) begin
                err_valid <= 1'b1;
                err_kind  <= ERR_INCOMPLETE;
              end
            end else begin
              rsp_rdata <= {8'h00, status_q};
            end
          end
          is_len: begin
            if (req_write) begin
              if (len_ok) begin
                length_q <= req_wdata[LW-1:0];
                cursor_q <= '0;
              end else begin
                err_valid <= 1'b1;
                err_kind  <= ERR_LEN;
              end
            end else begin
              rsp_rdata <= 16'(length_q);
            end
          end
          is_data: begin
            if (cur_ok) begin
              cursor_q <= cursor_q + 1'b1;
              if (!req_write) rsp_rdata <= {8'h00, buf_rdata};
            end else begin
              err_valid <= 1'b1;
              err_kind  <= ERR_RANGE;
            end
          end
          default: begin
            err_valid <= 1'b1;
            err_kind  <= ERR_OFFSET;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
  parameter int BUF_BYTES = 16,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [2:0]    req_addr,
  input logic [15:0]   req_wdata,
  input logic          rsp_valid,
  input logic          ext_cmd_valid,
  input logic [LW-1:0] length_q,
  input logic [LW-1:0] cursor_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R2
  length_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    length_q <= LW'(BUF_BYTES));

  // R3
  cursor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_q <= length_q);

  // R2
  length_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == 3'd2 && req_wdata <= 16'(BUF_BYTES))
    |=> (cursor_q == '0) && (length_q == $past(req_wdata[LW-1:0])));

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == 3'd0) |=> !req_ready);

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  // R11
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !req_write) |=> !rsp_valid);

  // R9
  ext_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cmd_valid |-> !req_ready);
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rsp_valid     (rsp_valid),
  .ext_cmd_valid (ext_cmd_valid),
  .length_q      (length_q),
  .cursor_q      (cursor_q)
);

// File: tb/mbx_mailbox_tb.sv
module mbx_mailbox_tb;
  localparam int          BUF = 8;
  localparam logic [15:0] VER = 16'hA55A;
  localparam logic [47:0] STN = 48'h0A1B2C3D4E5F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, err_valid, ext_cmd_valid;
  logic [15:0] rsp_rdata;
  logic [1:0] err_kind;
  logic [3:0] ext_cmd_code;

  always #4 clk = ~clk;

  mbx_mailbox #(.BUF_BYTES(BUF), .API_VER(VER), .STATION(STN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_valid(err_valid),
    .err_kind(err_kind), .ext_cmd_valid(ext_cmd_valid), .ext_cmd_code(ext_cmd_code)
  );

  typedef struct {
    logic        rv;
    logic [15:0] rd;
    logic        ev;
    logic [1:0]  ek;
    string       tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [3:0] ext_q[$];
  string      ext_tag_q[$];
  int vectors = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (rsp_valid || err_valid)) begin
      if (sb_q.size() == 0) begin
        chk("R11 unexpected output", {rsp_valid, err_valid}, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, {13'd0, rsp_valid, rsp_valid ? rsp_rdata : 16'd0, err_valid, err_valid ? err_kind : 2'd0},
                   {13'd0, e.rv, e.rd, e.ev, e.ek});
      end
    end
    if (rst_n && ext_cmd_valid) begin
      if (ext_q.size() == 0) chk("R9 unexpected dispatch", 1, 0);
      else chk(ext_tag_q.pop_front(), ext_cmd_code, ext_q.pop_front());
    end
  end

  task automatic access(input logic w, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    access(1'b1, a, d);
  endtask

  task automatic wr_err(input logic [2:0] a, input logic [15:0] d, input logic [1:0] k, input string tag);
    sb_q.push_back('{1'b0, 16'd0, 1'b1, k, tag});
    access(1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    sb_q.push_back('{1'b1, e, 1'b0, 2'd0, tag});
    access(1'b0, a, 16'd0);
  endtask

  task automatic rd_err(input logic [2:0] a, input logic [1:0] k, input string tag);
    sb_q.push_back('{1'b1, 16'd0, 1'b1, k, tag});
    access(1'b0, a, 16'd0);
  endtask

  task automatic cmd(input logic [15:0] c);
    wr(3'd0, c);
    chk("R4 ready low while running", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 outputs idle", {rsp_valid, err_valid, ext_cmd_valid}, 0);
    rd(3'd0, 16'd0, "R1 status");
    rd(3'd2, 16'd0, "R1 length");
    // R6 no-op
    cmd(16'd0);
    rd(3'd0, 16'd0, "R6 nop status");
    rd(3'd2, 16'd0, "R6 nop length");
    // R6 version, low byte first; cursor back at 0 (R4)
    cmd(16'd1);
    rd(3'd2, 16'd2, "R6 ver length");
    rd(3'd4, 16'h005A, "R6 ver byte0");
    rd(3'd4, 16'h00A5, "R6 ver byte1");
    rd_err(3'd4, 2'd1, "R3 read past length");
    // R7 station address, MSB first
    cmd(16'd2);
    rd(3'd2, 16'd6, "R7 length");
    rd(3'd0, 16'd0, "R7 status");
    for (int i = 0; i < 6; i++) rd(3'd4, {8'h00, STN[8*(5-i) +: 8]}, "R7 station byte");
    // R3 loopback
    wr(3'd2, 16'd3);
    wr(3'd4, 16'hFF11); wr(3'd4, 16'h0022); wr(3'd4, 16'h0033);
    wr_err(3'd4, 16'h0044, 2'd1, "R3 write past length");
    wr(3'd2, 16'd3);
    rd(3'd4, 16'h0011, "R3 loop byte0");
    rd(3'd4, 16'h0022, "R3 loop byte1");
    rd(3'd4, 16'h0033, "R3 loop byte2");
    rd_err(3'd4, 2'd1, "R3 read past length loop");
    // R2 length boundary
    wr(3'd2, BUF);
    rd(3'd2, BUF, "R2 max length accepted");
    wr_err(3'd2, BUF + 1, 2'd0, "R2 oversize length");
    rd(3'd2, BUF, "R2 length unchanged");
    rd(3'd4, 16'h0011, "R2 cursor unchanged");
    // R5 incomplete data
    wr(3'd2, 16'd2);
    wr(3'd4, 16'h0077);
    sb_q.push_back('{1'b0, 16'd0, 1'b1, 2'd2, "R5 incomplete"});
    cmd(16'd0);
    rd(3'd0, 16'd0, "R5 status after");
    rd(3'd2, 16'd0, "R5 length after");
    // R8 unknown command
    cmd(16'd9);
    rd(3'd0, 16'd1, "R8 unknown status");
    rd(3'd2, 16'd0, "R8 unknown length");
    cmd(16'h0101);
    rd(3'd0, 16'd1, "R8 wide unknown status");
    // R9 external dispatch
    ext_q.push_back(4'd5); ext_tag_q.push_back("R9 dispatch code 5");
    cmd(16'd5);
    rd(3'd0, 16'd0, "R9 status ok");
    ext_q.push_back(4'd8); ext_tag_q.push_back("R9 dispatch code 8");
    cmd(16'd8);
    rd(3'd2, 16'd0, "R9 length zero");
    // R10 bad offsets
    rd_err(3'd6, 2'd3, "R10 bad offset read");
    wr_err(3'd6, 16'd3, 2'd3, "R10 bad offset write");
    wr_err(3'd1, 16'd3, 2'd3, "R10 odd offset write");
    rd(3'd2, 16'd0, "R10 length untouched");
    rd(3'd0, 16'd0, "R10 status untouched");
    repeat (4) @(negedge clk);
    chk("R11 scoreboard drained", sb_q.size(), 0);
    chk("R9 dispatch drained", ext_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule